// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block counts down a programmable interval on a fixed 33 MHz reference clock, and it does so in two stages. When the first stage runs out, the block sends a warning interrupt. It then loads the second-stage interval and keeps counting. When the second stage runs out, the block can request a system reset and record that request in a sticky flag. Software keeps the system alive by pinging the block, which restarts the count from the first stage.

The block takes already-decoded register write strobes from a separate bus and unlock block:

- **Config write:** sets the reset-enable control, the count rate and the interrupt kind.
- **Control write:** sets the lock, enable and free-run bits.
- **Preload writes:** one for each stage.
- **Ping:** a keep-alive pulse.

A prescaler divides the reference clock into counts of 2^15 clocks (slow rate) or 2^5 clocks (fast rate). Free-run mode rearms the first stage after the second stage runs out. The lock bit freezes the control bits until reset.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, every output is 0:
  - the control readback `ctl_rdata`, `in_stage2`, `irq_out`, `smi_out`, `reset_req` and `prev_reboot`.
  - The reset values of the registers are: both preloads 0xFFFFF, reset request enabled, slow rate, interrupt kind 0.
- R2: A stage with preload P lasts (P+1) counts.
  - A count is 32 reference clocks when config bit 2 is 1, and 32768 clocks when it is 0.
  - The first-stage expiry is registered on the edge that is 32*(P1+1) (fast rate) clocks after the edge that started the count.
- R3: When stage one expires, the interrupt output follows config bits 1:0:
  - value 0 gives a one-cycle `irq_out` pulse;
  - value 2 gives a one-cycle `smi_out` pulse;
  - values 1 and 3 give no pulse.
  - On the same edge the block loads the stage-two preload and sets `in_stage2`.
- R4: When stage two expires with config bit 5 = 0, `reset_req` pulses for one cycle and `prev_reboot` is set. With bit 5 = 1, neither happens.
- R5: After stage two expires, the count restarts at stage one from the stage-one preload if the free-run bit is set. Otherwise the count stops.
- R6: A control write turning the enable bit (bit 1) from 0 to 1 starts stage one. A control write that keeps enable at 1 does not restart the count. A control write with enable 0 stops it.
- R7: A ping while enabled restarts stage one from the stage-one preload and clears the prescaler. A ping while disabled has no effect.
- R8: A ping on the same edge as an expiry wins: no interrupt or reset pulse occurs, and the count restarts at stage one.
- R9: The control bits are bit 0 = lock, bit 1 = enable and bit 2 = free-run, and they are read back on `ctl_rdata` in the same positions. Once lock is 1, control writes are ignored until reset.
- R10: `prev_reboot` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_wdata | input | 6 | Config data: bit 5 reset disable, bit 2 fast rate, bits 1:0 interrupt kind |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control data: bit 2 free-run, bit 1 enable, bit 0 lock |
| pre1_we | input | 1 | Stage-one preload write strobe |
| pre2_we | input | 1 | Stage-two preload write strobe |
| pre_wdata | input | 20 | Preload value |
| ping | input | 1 | Keep-alive pulse |
| ctl_rdata | output | 3 | Control bits readback |
| in_stage2 | output | 1 | High while the count is in stage two |
| irq_out | output | 1 | Warning interrupt pulse, normal kind |
| smi_out | output | 1 | Warning interrupt pulse, management kind |
| reset_req | output | 1 | One-cycle system reset request |
| prev_reboot | output | 1 | Sticky flag: a reset was requested |

## Verification
The assertions check the following on every cycle:
- the interrupt and reset pulses last one cycle;
- a reset request always comes with the sticky flag;
- the flag never drops;
- locked control bits never move;
- stage two is entered only on a prescaler tick;
- a ping always wins over an expiry.

Only the bench scenarios can show the following:
- the exact expiry cycles for each preload and rate;
- that free-run produces a repeating pattern;
- that a redundant enable write leaves the schedule untouched;
- that pings while disabled and writes while locked leave the outputs unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        KIND_IRQ  = 2'd0,
        KIND_RSV  = 2'd1,
        KIND_SMI  = 2'd2,
        KIND_NONE = 2'd3
    } int_kind_e;

    // Field order matches the control word: bit 2, bit 1, bit 0
    typedef struct packed {
        logic fr;
        logic en;
        logic lk;
    } ctl_t;

    typedef struct packed {
        logic      reboot_n;
        logic      fast;
        int_kind_e kind;
    } cfg_t;

    localparam int CFG_W = 6;
    localparam int CTL_W = 3;

    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] d);
        cfg_t c;
        c.reboot_n = d[5];
        c.fast     = d[2];
        c.kind     = int_kind_e'(d[1:0]);
        return c;
    endfunction

    function automatic cfg_t cfg_default();
        cfg_t c;
        c.reboot_n = 1'b0;
        c.fast     = 1'b0;
        c.kind     = KIND_IRQ;
        return c;
    endfunction

endpackage

// File: rtl/wdt_ctl_regs.sv
module wdt_ctl_regs
    import wdt_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  ctl_we,
    input  logic [CTL_W-1:0]      ctl_wdata,
    input  logic                  pre1_we,
    input  logic                  pre2_we,
    input  logic [PRE_W-1:0]      pre_wdata,
    output cfg_t                  cfg,
    output ctl_t                  ctl,
    output logic [PRE_W-1:0]      pre1,
    output logic [PRE_W-1:0]      pre2,
    output logic                  start,
    output logic                  stop
);

    ctl_t wr;
    logic ctl_take;

    assign wr       = ctl_t'(ctl_wdata);
    assign ctl_take = ctl_we && !ctl.lk;
    assign start    = ctl_take && wr.en && !ctl.en;
    assign stop     = ctl_take && !wr.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= cfg_default();
            ctl  <= '0;
            pre1 <= '1;
            pre2 <= '1;
        end else begin
            if (cfg_we)   cfg  <= decode_cfg(cfg_wdata);
            if (ctl_take) ctl  <= wr;
            if (pre1_we)  pre1 <= pre_wdata;
            if (pre2_we)  pre2 <= pre_wdata;
        end
    end

    // Once locked, the control word must not move until reset
    p_lock_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        ctl.lk |=> $stable(ctl));

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic fast,
    output logic tick
);

    logic [SLOW_SHIFT-1:0] presc;

    assign tick = run && (fast ? (&presc[FAST_SHIFT-1:0]) : (&presc));

    always_ff @(posedge clk) begin
        if (rst || clear) presc <= '0;
        else if (run)     presc <= presc + 1'b1;
    end

    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic             ping,
    input  logic             en,
    input  logic             free_run,
    input  logic             reboot_n,
    input  int_kind_e        kind,
    input  logic [PRE_W-1:0] pre1,
    input  logic [PRE_W-1:0] pre2,
    output logic             active,
    output logic             stage2,
    output logic             irq,
    output logic             smi,
    output logic             rst_req,
    output logic             prev,
    output logic             presc_clear
);

    logic [PRE_W-1:0] cnt;
    logic             kick;

    assign kick        = start || (ping && en);
    assign presc_clear = stop || kick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            active  <= 1'b0;
            stage2  <= 1'b0;
            irq     <= 1'b0;
            smi     <= 1'b0;
            rst_req <= 1'b0;
            prev    <= 1'b0;
        end else begin
            irq     <= 1'b0;
            smi     <= 1'b0;
            rst_req <= 1'b0;
            if (stop) begin
                active <= 1'b0;
                stage2 <= 1'b0;
            end else if (kick) begin
                active <= 1'b1;
                stage2 <= 1'b0;
                cnt    <= pre1;
            end else if (tick) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (!stage2) begin
                    irq    <= (kind == KIND_IRQ);
                    smi    <= (kind == KIND_SMI);
                    stage2 <= 1'b1;
                    cnt    <= pre2;
                end else begin
                    if (!reboot_n) begin
                        rst_req <= 1'b1;
                        prev    <= 1'b1;
                    end
                    if (free_run) begin
                        stage2 <= 1'b0;
                        cnt    <= pre1;
                    end else begin
                        active <= 1'b0;
                    end
                end
            end
        end
    end

    p_req_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> prev);

    p_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
        (irq || smi) |=> !(irq || smi));

    p_req_single_r4: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    p_kinds_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(irq && smi));

    p_ping_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (ping && en && !stop) |=> (active && !stage2 && !irq && !smi && !rst_req));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        prev |=> prev);

    p_stage2_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(stage2) |-> $past(tick));

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int PRE_W      = 20,
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_wdata,
    input  logic              ctl_we,
    input  logic [2:0]        ctl_wdata,
    input  logic              pre1_we,
    input  logic              pre2_we,
    input  logic [PRE_W-1:0]  pre_wdata,
    input  logic              ping,
    output logic [2:0]        ctl_rdata,
    output logic              in_stage2,
    output logic              irq_out,
    output logic              smi_out,
    output logic              reset_req,
    output logic              prev_reboot
);

    cfg_t             cfg;
    ctl_t             ctl;
    logic [PRE_W-1:0] pre1;
    logic [PRE_W-1:0] pre2;
    logic             start;
    logic             stop;
    logic             tick;
    logic             active;
    logic             presc_clear;

    wdt_ctl_regs #(.PRE_W(PRE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .pre1_we   (pre1_we),
        .pre2_we   (pre2_we),
        .pre_wdata (pre_wdata),
        .cfg       (cfg),
        .ctl       (ctl),
        .pre1      (pre1),
        .pre2      (pre2),
        .start     (start),
        .stop      (stop)
    );

    wdt_prescale #(.SLOW_SHIFT(SLOW_SHIFT), .FAST_SHIFT(FAST_SHIFT)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .clear (presc_clear),
        .run   (active),
        .fast  (cfg.fast),
        .tick  (tick)
    );

    wdt_countdown #(.PRE_W(PRE_W)) u_count (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .start       (start),
        .stop        (stop),
        .ping        (ping),
        .en          (ctl.en),
        .free_run    (ctl.fr),
        .reboot_n    (cfg.reboot_n),
        .kind        (cfg.kind),
        .pre1        (pre1),
        .pre2        (pre2),
        .active      (active),
        .stage2      (in_stage2),
        .irq         (irq_out),
        .smi         (smi_out),
        .rst_req     (reset_req),
        .prev        (prev_reboot),
        .presc_clear (presc_clear)
    );

    assign ctl_rdata = ctl;

endmodule

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;

    localparam int KI = 0, KS = 1, KR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_wdata = '0;
    logic        pre1_we = 1'b0;
    logic        pre2_we = 1'b0;
    logic [19:0] pre_wdata = '0;
    logic        ping = 1'b0;
    logic [2:0]  ctl_rdata;
    logic        in_stage2, irq_out, smi_out, reset_req, prev_reboot;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int    at;
        int    kind;
        string tag;
    } ev_t;
    ev_t q[$];

    wdt_two_stage dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .pre1_we(pre1_we),
        .pre2_we(pre2_we), .pre_wdata(pre_wdata), .ping(ping),
        .ctl_rdata(ctl_rdata), .in_stage2(in_stage2), .irq_out(irq_out),
        .smi_out(smi_out), .reset_req(reset_req), .prev_reboot(prev_reboot)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(input int at, input int kind, input string tag);
        ev_t e;
        e.at = at; e.kind = kind; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: every pulse must match the front of the queue at its cycle
    task automatic seen(input int kind);
        if (q.size() == 0) begin
            chk(0, "unexpected pulse", kind, -1);
        end else if (q[0].at != cyc || q[0].kind != kind) begin
            chk(0, q[0].tag, cyc * 4 + kind, q[0].at * 4 + q[0].kind);
        end else begin
            chk(1, q[0].tag, kind, kind);
            void'(q.pop_front());
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (irq_out)   seen(KI);
            if (smi_out)   seen(KS);
            if (reset_req) seen(KR);
            while (q.size() > 0 && q[0].at < cyc) begin
                chk(0, {q[0].tag, " missed"}, -1, q[0].at);
                void'(q.pop_front());
            end
        end
    end

    // Driver tasks: called at a negedge, the write lands on the next edge
    task automatic wr_cfg(input logic [5:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [2:0] d, output int e);
        ctl_we = 1'b1; ctl_wdata = d; e = cyc + 1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_pre(input logic [19:0] p1, input logic [19:0] p2);
        pre1_we = 1'b1; pre_wdata = p1;
        @(negedge clk);
        pre1_we = 1'b0; pre2_we = 1'b1; pre_wdata = p2;
        @(negedge clk);
        pre2_we = 1'b0;
    endtask

    task automatic do_ping(output int e);
        ping = 1'b1; e = cyc + 1;
        @(negedge clk);
        ping = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        int e, e2, p, p2, d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk({ctl_rdata, in_stage2, irq_out, smi_out, reset_req, prev_reboot} == 8'd0,
            "R1 reset outputs", {ctl_rdata, in_stage2, irq_out, smi_out, reset_req, prev_reboot}, 0);

        // A: fast, IRQ, reset disabled; R2 R3 R4 R6
        wr_cfg(6'b100100);
        wr_pre(20'd3, 20'd1);
        wr_ctl(3'b010, e);
        expect_ev(e + 128, KI, "R2 R3 stage-one irq timing");
        wait_until(e + 50);
        wr_ctl(3'b010, d);              // R6: redundant enable, no restart
        wait_until(e + 138);
        chk(in_stage2 == 1'b1, "R3 in stage two", in_stage2, 1);
        wait_until(e + 200);
        chk(prev_reboot == 1'b0, "R4 no flag when disabled", prev_reboot, 0);
        chk(ctl_rdata == 3'b010, "R9 readback enable", ctl_rdata, 3'b010);
        wr_ctl(3'b000, d);

        // B: SMI, reset enabled; R3 R4 R5 R10
        wr_cfg(6'b000110);
        wr_pre(20'd1, 20'd0);
        wr_ctl(3'b010, e);
        expect_ev(e + 64, KS, "R3 smi pulse");
        expect_ev(e + 96, KR, "R4 reset request");
        wait_until(e + 100);
        chk(prev_reboot == 1'b1, "R4 flag set", prev_reboot, 1);
        wait_until(e + 300);            // R5: no free-run, no further pulses
        chk(prev_reboot == 1'b1, "R10 flag sticky", prev_reboot, 1);
        chk(q.size() == 0, "R5 stopped", q.size(), 0);
        wr_ctl(3'b000, d);

        // C: ping restarts; R7
        wr_cfg(6'b000100);
        wr_pre(20'd3, 20'd1);
        wr_ctl(3'b010, e);
        wait_until(e + 100);
        do_ping(p);
        expect_ev(p + 128, KI, "R7 ping restart irq");
        wait_until(p + 150);
        do_ping(p2);
        chk(in_stage2 == 1'b0, "R7 ping returns to stage one", in_stage2, 0);
        expect_ev(p2 + 128, KI, "R7 irq after second ping");
        expect_ev(p2 + 192, KR, "R7 reset after second ping");
        wait_until(p2 + 260);
        wr_ctl(3'b000, d);

        // D: ping while disabled; R7
        do_ping(p);
        wait_until(p + 300);
        chk(q.size() == 0 && ctl_rdata == 3'b000 && in_stage2 == 1'b0,
            "R7 ping ignored when disabled", ctl_rdata, 0);

        // E: ping on the expiry edge; R8
        wr_pre(20'd1, 20'd0);
        wr_ctl(3'b010, e);
        wait_until(e + 63);
        do_ping(p);
        chk(p == e + 64, "R8 ping aligned", p, e + 64);
        chk(in_stage2 == 1'b0, "R8 stays in stage one", in_stage2, 0);
        expect_ev(p + 64, KI, "R8 irq after winning ping");
        expect_ev(p + 96, KR, "R8 reset after winning ping");
        wait_until(p + 120);
        wr_ctl(3'b000, d);

        // F: free-run; R5
        wr_pre(20'd0, 20'd0);
        wr_ctl(3'b110, e);
        expect_ev(e + 32,  KI, "R5 free-run irq 1");
        expect_ev(e + 64,  KR, "R5 free-run reset 1");
        expect_ev(e + 96,  KI, "R5 free-run irq 2");
        expect_ev(e + 128, KR, "R5 free-run reset 2");
        wait_until(e + 140);
        wr_ctl(3'b000, d);
        wait_until(e + 260);

        // G: slow rate, reset disabled; R2
        wr_cfg(6'b100000);
        wr_ctl(3'b010, e);
        expect_ev(e + 32768, KI, "R2 slow-rate irq");
        wait_until(e + 32770);
        chk(in_stage2 == 1'b1, "R2 slow stage two", in_stage2, 1);
        wait_until(e + 65600);
        wr_ctl(3'b000, d);

        // H: lock; R9
        wr_cfg(6'b000100);
        wr_pre(20'd1, 20'd0);
        wr_ctl(3'b011, e);
        expect_ev(e + 64, KI, "R9 locked irq");
        expect_ev(e + 96, KR, "R9 locked reset");
        wait_until(e + 10);
        wr_ctl(3'b000, d);
        chk(ctl_rdata == 3'b011, "R9 write ignored when locked", ctl_rdata, 3'b011);
        wait_until(e + 110);
        wr_ctl(3'b110, d);
        chk(ctl_rdata == 3'b011, "R9 free-run ignored when locked", ctl_rdata, 3'b011);
        wait_until(e + 400);

        // I: reset clears lock and flag; R1 R9 R10
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(prev_reboot == 1'b0, "R10 flag cleared by reset", prev_reboot, 0);
        chk(ctl_rdata == 3'b000, "R1 R9 lock cleared by reset", ctl_rdata, 0);

        @(negedge clk);
        chk(q.size() == 0, "all expected pulses seen", q.size(), 0);
        finish_run();
    end

endmodule